// File: doc/BRIEF.md
# Mode Register Latency Controller

This block holds the latency and burst settings of a DRAM device model and turns them into read timing. Writes to mode register 0 set the CAS latency code, the burst mode, a test-mode bit, a write-recovery code and a DLL-reset request. Writes to mode register 1 pick the additive latency as 0, CL-1 or CL-2. The block decodes these fields into cycle counts and reports CL, AL and the read latency RL = AL + CL. All latencies are whole clock cycles.

A DLL-reset request starts a small lock sequencer with the states DLL_OFF, DLL_LOCKING and DLL_LOCKED. It has four transitions:
- DLL_OFF to DLL_LOCKING on a reset request.
- DLL_LOCKING back to DLL_LOCKING, which restarts the count, on a new request.
- DLL_LOCKING to DLL_LOCKED when LOCK_CYC cycles have elapsed.
- DLL_LOCKED to DLL_LOCKING on a new request.

Read strobes are accepted only in DLL_LOCKED. Each accepted read is placed in a shift schedule. The schedule raises a data-valid window RL cycles later, 8 cycles long for a full burst and 4 for a chopped one, and overlapping windows merge.

Top module: `mrs_latency_ctrl`

## Requirements
- R1: After reset the outputs hold the following values: cl=5, al=0, rl=5, burst_mode=0 (fixed 8), dll_locked=0, data_valid=0, cfg_err=0, test_mode=0, wr_short=0.
- R2: A register write to mode register 0 (mrs_stb=1, mr_sel=0) with a valid code takes effect one cycle later. Bits [6:4] hold the CL code, and codes 1..7 give CL = code+4. Bits [1:0] select the burst mode: 00 gives burst_mode 0 (fixed 8), 01 gives 1 (on the fly), and 10 or 11 give 2 (fixed chop 4).
- R3: A register write to mode register 1 (mr_sel=1) selects the AL with bits [4:3]: 00 gives AL=0, 01 gives AL=CL-1 and 10 gives AL=CL-2. AL follows later CL changes.
- R4: rl always equals al+cl.
- R5: An MR0 write with CL code 0, or an MR1 write with AL select 11, changes no setting and sets cfg_err to 1. The next accepted MR0 or MR1 write clears cfg_err. Writes with mr_sel 2 or 3 change nothing, including cfg_err.
- R6: An accepted MR0 write with bit 8 set drops dll_locked in the next cycle. dll_locked rises exactly LOCK_CYC cycles after the edge that sampled the write.
- R7: The DLL-reset bit is not retained. Once locked, dll_locked stays high through any number of cycles, MR1 writes and MR0 writes whose bit 8 is clear.
- R8: rd_stb is ignored while dll_locked is low, and no data-valid window follows it.
- R9: A read accepted at edge E drives data_valid high after edges E+RL through E+RL+len-1. RL is the value in effect before edge E, so an MR write in the same cycle does not alter that read.
- R10: len is 8 in burst mode 0 and 4 in burst mode 2. In burst mode 1, rd_bc_n=1 gives 8 and rd_bc_n=0 gives 4.
- R11: Windows of overlapping reads merge into their union.
- R12: test_mode mirrors bit 7 of the last accepted MR0 write.
- R13: Bits [11:9] of MR0 are a write-recovery code worth code+5 cycles. wr_short is 1 when that value is below WR_MIN (default 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_stb | input | 1 | Mode register write strobe |
| mr_sel | input | 2 | Register select (0 = MR0, 1 = MR1) |
| mr_val | input | 16 | Value written to the selected register |
| rd_stb | input | 1 | Read command strobe |
| rd_bc_n | input | 1 | Burst length bit of the read in on-the-fly mode (0 = chop) |
| cl | output | 5 | CAS latency in cycles |
| al | output | 5 | Additive latency in cycles |
| rl | output | 5 | Read latency in cycles |
| burst_mode | output | 2 | 0 fixed 8, 1 on the fly, 2 fixed chop |
| dll_locked | output | 1 | DLL lock interval complete |
| data_valid | output | 1 | Read data window |
| cfg_err | output | 1 | Last MR0/MR1 write was rejected |
| test_mode | output | 1 | Test mode bit set |
| wr_short | output | 1 | Write recovery below minimum |

## Verification
A read strobe and an MR1 write that changes the additive latency can fall on the same clock edge. The bench drives both in one cycle. The scoreboard then expects that read's window at the old RL, and a later direct check confirms the new AL and RL on the outputs. The same style of check covers a DLL reset while locked followed at once by a read, which must produce no window.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
    localparam int CL_CODE_W = 3;
    localparam int CL_BASE   = 4;
    localparam int CL_MAX    = CL_BASE + (1 << CL_CODE_W) - 1;
    localparam int RL_MAX    = 2 * CL_MAX - 1;
    localparam int LAT_W     = $clog2(RL_MAX + 1);
    localparam int WR_CODE_W = 3;
    localparam int WR_BASE   = 5;

    typedef enum logic [1:0] {
        BM_FIXED8 = 2'd0,
        BM_OTF    = 2'd1,
        BM_CHOP4  = 2'd2
    } burst_mode_e;

    typedef enum logic [1:0] {
        AL_ZERO = 2'd0,
        AL_CLM1 = 2'd1,
        AL_CLM2 = 2'd2
    } al_sel_e;

    typedef enum logic [1:0] {
        DLL_OFF     = 2'd0,
        DLL_LOCKING = 2'd1,
        DLL_LOCKED  = 2'd2
    } dll_state_e;
endpackage

// File: rtl/mrl_mode_regs.sv
module mrl_mode_regs
    import mrl_pkg::*;
#(
    parameter int WR_MIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_stb,
    input  logic [1:0]       mr_sel,
    input  logic [15:0]      mr_val,
    output logic [LAT_W-1:0] cl,
    output logic [LAT_W-1:0] al,
    output logic [LAT_W-1:0] rl,
    output burst_mode_e      burst_mode,
    output logic             cfg_err,
    output logic             test_mode,
    output logic             wr_short,
    output logic             dll_restart
);
    logic [CL_CODE_W-1:0] cl_code_q;
    logic [1:0]           bm_raw_q;
    logic [WR_CODE_W-1:0] wr_code_q;
    logic [1:0]           al_sel_q;
    logic                 err_q;
    logic                 test_q;

    logic is_mr0, is_mr1, mr0_ok, mr1_ok;
    logic unused_bits;

    assign is_mr0 = mrs_stb && (mr_sel == 2'd0);
    assign is_mr1 = mrs_stb && (mr_sel == 2'd1);
    assign mr0_ok = (mr_val[6:4] != '0);
    assign mr1_ok = (mr_val[4:3] != 2'b11);
    assign dll_restart = is_mr0 && mr0_ok && mr_val[8];
    assign unused_bits = ^{mr_val[15:12], mr_val[2]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_code_q <= CL_CODE_W'(1);
            bm_raw_q  <= 2'b00;
            wr_code_q <= WR_CODE_W'(3);
            al_sel_q  <= AL_ZERO;
            err_q     <= 1'b0;
            test_q    <= 1'b0;
        end else if (is_mr0) begin
            if (mr0_ok) begin
                cl_code_q <= mr_val[6:4];
                bm_raw_q  <= mr_val[1:0];
                wr_code_q <= mr_val[11:9];
                test_q    <= mr_val[7];
                err_q     <= 1'b0;
            end else begin
                err_q <= 1'b1;
            end
        end else if (is_mr1) begin
            if (mr1_ok) begin
                al_sel_q <= mr_val[4:3];
                err_q    <= 1'b0;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    // translation of the stored CL code into cycles
    function automatic logic [LAT_W-1:0] cl_cycles(input logic [CL_CODE_W-1:0] code);
        return LAT_W'(CL_BASE) + LAT_W'(code);
    endfunction

    always_comb begin
        cl = cl_cycles(cl_code_q);
        unique case (al_sel_q)
            AL_CLM1: al = cl - LAT_W'(1);
            AL_CLM2: al = cl - LAT_W'(2);
            default: al = '0;
        endcase
        rl = al + cl;
        unique case (bm_raw_q)
            2'b00:   burst_mode = BM_FIXED8;
            2'b01:   burst_mode = BM_OTF;
            default: burst_mode = BM_CHOP4;
        endcase
    end

    assign cfg_err   = err_q;
    assign test_mode = test_q;
    assign wr_short  = (int'(wr_code_q) + WR_BASE) < WR_MIN;

    // R5: rejected MR0 write leaves CL and raises the error
    a_r5_keep_cl: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mr0 && !mr0_ok) |=> ($stable(cl) && cfg_err));
    // R5: rejected MR1 write leaves AL selection
    a_r5_keep_al: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mr1 && !mr1_ok) |=> ($stable(al) && cfg_err));
    // R12: test flag follows accepted MR0 write
    a_r12_test_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mr0 && mr0_ok) |=> (test_mode == $past(mr_val[7])));
    // R3: AL is one of the three legal choices
    a_r3_al_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (al == '0) || (al == cl - LAT_W'(1)) || (al == cl - LAT_W'(2)));
endmodule

// File: rtl/mrl_dll_fsm.sv
module mrl_dll_fsm
    import mrl_pkg::*;
#(
    parameter int LOCK_CYC = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic locked
);
    localparam int CNT_W = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYC - 1);

    dll_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DLL_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (restart) begin
                cnt_q <= '0;
            end else if (state_q == DLL_LOCKING && cnt_q != CNT_LAST) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DLL_OFF:     if (restart) state_d = DLL_LOCKING;
            DLL_LOCKING: begin
                if (restart)                state_d = DLL_LOCKING;
                else if (cnt_q == CNT_LAST) state_d = DLL_LOCKED;
            end
            DLL_LOCKED:  if (restart) state_d = DLL_LOCKING;
            default:     state_d = DLL_OFF;
        endcase
    end

    always_comb begin
        locked = (state_q == DLL_LOCKED);
    end

    // R6: a restart always removes lock on the next cycle
    a_r6_drop_lock: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !locked);
    // R7: lock holds without a new restart
    a_r7_hold_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !restart) |=> locked);
    // R6: lock is only reached from the counting state
    a_r6_lock_path: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(state_q) == DLL_LOCKING));
endmodule

// File: rtl/mrl_read_window.sv
module mrl_read_window
    import mrl_pkg::*;
#(
    parameter int BURST_FULL = 8,
    parameter int BURST_CHOP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  logic             chop,
    input  logic [LAT_W-1:0] rl,
    output logic             data_valid
);
    localparam int DEPTH = RL_MAX + BURST_FULL + 1;

    logic [DEPTH-1:0] sched_q;
    logic [DEPTH-1:0] mask;
    int               len;

    assign len = chop ? BURST_CHOP : BURST_FULL;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign mask[i] = (i >= int'(rl)) && (i < int'(rl) + len);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sched_q <= '0;
        end else begin
            sched_q <= (sched_q >> 1) | (rd_go ? mask : '0);
        end
    end

    assign data_valid = sched_q[0];

    // R9: a fresh read into an empty schedule never shows at once
    a_r9_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && (sched_q == '0)) |=> !data_valid);
    // R10: a window once open lasts at least the chop length
    a_r10_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |=> data_valid);
endmodule

// File: rtl/mrs_latency_ctrl.sv
module mrs_latency_ctrl
    import mrl_pkg::*;
#(
    parameter int WR_MIN     = 8,
    parameter int LOCK_CYC   = 512,
    parameter int BURST_FULL = 8,
    parameter int BURST_CHOP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_stb,
    input  logic [1:0]       mr_sel,
    input  logic [15:0]      mr_val,
    input  logic             rd_stb,
    input  logic             rd_bc_n,
    output logic [LAT_W-1:0] cl,
    output logic [LAT_W-1:0] al,
    output logic [LAT_W-1:0] rl,
    output logic [1:0]       burst_mode,
    output logic             dll_locked,
    output logic             data_valid,
    output logic             cfg_err,
    output logic             test_mode,
    output logic             wr_short
);
    burst_mode_e bm;
    logic        dll_restart;
    logic        rd_go;
    logic        chop;

    mrl_mode_regs #(.WR_MIN(WR_MIN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrs_stb    (mrs_stb),
        .mr_sel     (mr_sel),
        .mr_val     (mr_val),
        .cl         (cl),
        .al         (al),
        .rl         (rl),
        .burst_mode (bm),
        .cfg_err    (cfg_err),
        .test_mode  (test_mode),
        .wr_short   (wr_short),
        .dll_restart(dll_restart)
    );

    mrl_dll_fsm #(.LOCK_CYC(LOCK_CYC)) u_dll (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(dll_restart),
        .locked (dll_locked)
    );

    assign rd_go = rd_stb && dll_locked;
    assign chop  = (bm == BM_CHOP4) || ((bm == BM_OTF) && !rd_bc_n);
    assign burst_mode = bm;

    mrl_read_window #(.BURST_FULL(BURST_FULL), .BURST_CHOP(BURST_CHOP)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_go     (rd_go),
        .chop      (chop),
        .rl        (rl),
        .data_valid(data_valid)
    );

    // R4: read latency tracks both components
    a_r4_rl_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (rl > cl) || (al == '0));
    // R8: nothing opens a window out of an idle, unlocked state
    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!dll_locked && !data_valid && $past(!dll_locked) && $past(!data_valid)
         && rd_stb) |=> !data_valid);
endmodule

// File: tb/mrs_latency_ctrl_bench.sv
module mrs_latency_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int LOCK  = 40;
    localparam int WRMIN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mrs_stb = 1'b0;
    logic [1:0]  mr_sel = 2'd0;
    logic [15:0] mr_val = '0;
    logic        rd_stb = 1'b0;
    logic        rd_bc_n = 1'b1;
    logic [4:0]  cl, al, rl;
    logic [1:0]  burst_mode;
    logic        dll_locked, data_valid, cfg_err, test_mode, wr_short;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int dv_seen = 0;
    int last_edge = 0;
    bit mon_on = 1'b0;
    int exp_q[$];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mrs_latency_ctrl #(.WR_MIN(WRMIN), .LOCK_CYC(LOCK)) u_mrs_latency_ctrl (
        .clk(clk), .rst_n(rst_n), .mrs_stb(mrs_stb), .mr_sel(mr_sel),
        .mr_val(mr_val), .rd_stb(rd_stb), .rd_bc_n(rd_bc_n),
        .cl(cl), .al(al), .rl(rl), .burst_mode(burst_mode),
        .dll_locked(dll_locked), .data_valid(data_valid), .cfg_err(cfg_err),
        .test_mode(test_mode), .wr_short(wr_short)
    );

    function automatic logic [15:0] mk0(int bm, int clc, int tm, int dll, int wr);
        logic [15:0] v = '0;
        v[1:0]  = bm[1:0];
        v[6:4]  = clc[2:0];
        v[7]    = tm[0];
        v[8]    = dll[0];
        v[11:9] = wr[2:0];
        return v;
    endfunction

    function automatic logic [15:0] mk1(int sel);
        logic [15:0] v = '0;
        v[4:3] = sel[1:0];
        return v;
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic void push_exp(int s);
        int k = 0;
        while (k < exp_q.size() && exp_q[k] < s) k++;
        if (k < exp_q.size() && exp_q[k] == s) return;
        exp_q.insert(k, s);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (data_valid) dv_seen++;
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                checks++;
                if (!data_valid) begin
                    errors++;
                    $display("FAIL R9 data_valid at cycle %0d got 0 expected 1", cyc);
                end
                void'(exp_q.pop_front());
            end else if (data_valid) begin
                checks++;
                errors++;
                $display("FAIL R9 data_valid at cycle %0d got 1 expected 0", cyc);
            end
        end
    end

    task automatic mrs(int sel, logic [15:0] v);
        @(negedge clk);
        mrs_stb = 1'b1; mr_sel = sel[1:0]; mr_val = v;
        last_edge = cyc + 1;
        @(negedge clk);
        mrs_stb = 1'b0;
    endtask

    task automatic rd(bit bc_n, int len, int lat);
        @(negedge clk);
        rd_stb = 1'b1; rd_bc_n = bc_n;
        for (int i = 0; i < len; i++) push_exp(cyc + 1 + lat + i);
        @(negedge clk);
        rd_stb = 1'b0; rd_bc_n = 1'b1;
    endtask

    task automatic drain();
        repeat (35) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        // R1 reset state
        chk("R1 cl", cl, 5); chk("R1 al", al, 0); chk("R1 rl", rl, 5);
        chk("R1 burst_mode", burst_mode, 0); chk("R1 dll_locked", dll_locked, 0);
        chk("R1 data_valid", data_valid, 0); chk("R1 cfg_err", cfg_err, 0);
        chk("R1 test_mode", test_mode, 0); chk("R1 wr_short", wr_short, 0);

        // R8 read while never locked
        dv_seen = 0;
        rd(1'b1, 0, 0);
        drain();
        chk("R8 window while unlocked", dv_seen, 0);

        // R2 and R6: CL code 3, fixed 8, DLL reset
        mrs(0, mk0(0, 3, 0, 1, 3));
        chk("R2 cl", cl, 7); chk("R2 burst_mode", burst_mode, 0);
        chk("R6 locked after restart", dll_locked, 0);
        repeat (LOCK - 1) @(negedge clk);
        chk("R6 locked one cycle early", dll_locked, 0);
        @(negedge clk);
        chk("R6 locked at LOCK_CYC", dll_locked, 1);

        // R3 R4 AL = CL-1
        mrs(1, mk1(1));
        chk("R3 al cl-1", al, 6); chk("R4 rl", rl, 13);
        rd(1'b1, 8, 13);           // R9 full burst
        drain();

        // R10 fixed chop, R7 lock kept across MR0 without DLL bit
        mrs(0, mk0(2, 3, 0, 0, 3));
        chk("R2 burst chop", burst_mode, 2);
        chk("R7 lock kept", dll_locked, 1);
        rd(1'b1, 4, 13);
        drain();

        // R10 on the fly
        mrs(0, mk0(1, 3, 0, 0, 3));
        chk("R2 burst otf", burst_mode, 1);
        rd(1'b0, 4, 13);
        drain();
        rd(1'b1, 8, 13);
        drain();

        // R11 overlapping reads
        mrs(0, mk0(0, 3, 0, 0, 3));
        rd(1'b1, 8, 13);
        @(negedge clk);
        rd(1'b1, 8, 13);
        drain();
        chk("R11 queue drained", exp_q.size(), 0);

        // R9 read and MR1 write in the same cycle: old RL applies
        @(negedge clk);
        rd_stb = 1'b1; mrs_stb = 1'b1; mr_sel = 2'd1; mr_val = mk1(0);
        for (int i = 0; i < 8; i++) push_exp(cyc + 1 + 13 + i);
        @(negedge clk);
        rd_stb = 1'b0; mrs_stb = 1'b0;
        chk("R9 al after same-cycle write", al, 0);
        chk("R9 rl after same-cycle write", rl, 7);
        drain();

        // R3 AL tracks CL
        mrs(1, mk1(2));
        chk("R3 al cl-2", al, 5); chk("R4 rl", rl, 12);
        mrs(0, mk0(0, 7, 0, 0, 3));
        chk("R2 cl code 7", cl, 11); chk("R3 al follows cl", al, 9);
        chk("R4 rl 20", rl, 20);

        // R5 rejected writes
        mrs(0, mk0(2, 0, 1, 1, 0));
        chk("R5 cl kept", cl, 11); chk("R5 err set", cfg_err, 1);
        chk("R5 burst kept", burst_mode, 0); chk("R5 lock kept", dll_locked, 1);
        mrs(1, mk1(2));
        chk("R5 err cleared", cfg_err, 0);
        mrs(1, mk1(3));
        chk("R5 al kept", al, 9); chk("R5 err set mr1", cfg_err, 1);
        mrs(2, 16'hFFFF);
        chk("R5 sel2 err unchanged", cfg_err, 1);
        chk("R5 sel2 cl unchanged", cl, 11);
        mrs(0, mk0(0, 7, 0, 0, 3));
        chk("R5 err cleared mr0", cfg_err, 0);

        // R12 R13 test flag and write recovery
        mrs(0, mk0(0, 7, 1, 0, 0));
        chk("R12 test_mode", test_mode, 1); chk("R13 wr_short", wr_short, 1);
        mrs(0, mk0(0, 7, 0, 0, 3));
        chk("R12 test_mode clear", test_mode, 0);
        chk("R13 wr_short clear", wr_short, 0);

        // R6 R8 DLL reset while locked, read ignored
        mrs(0, mk0(0, 7, 0, 1, 3));
        chk("R6 lock dropped", dll_locked, 0);
        dv_seen = 0;
        rd(1'b1, 0, 0);
        drain();
        chk("R8 read ignored while relocking", dv_seen, 0);
        repeat (LOCK) @(negedge clk);
        chk("R6 relocked", dll_locked, 1);

        // R9 longest latency
        rd(1'b1, 8, 20);
        drain();
        chk("R9 queue drained", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule